// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block is a divide-by-ten sequencer. Its state is held in a five-stage twisted ring and is decoded into ten active-high select lines, one for each count. A carry line is active low while the count is in the upper half of the decade, so a chain of these blocks can be cascaded. Two count inputs of opposite edge sense work as a clock and enable pair. The first counts on its rising edge while the second is low. The second counts on its falling edge while the first is high. Every other edge or level leaves the count where it is.

The whole block runs on one system clock. Both count inputs pass through synchronizer flops and are then edge-detected, so neither one ever drives a clock pin. A master clear returns the block to count zero and overrides everything else. Feedback correction into the second ring stage pulls any unused ring pattern back into the legal ten-state loop within a few advances. A debug load port can write any 5-bit ring pattern, which is how illegal states are put in for test.

Top module: `ring10_counter`

## Requirements
- R1: Starting from count zero, each advance moves the count from k to (k+1) mod 10. `dec_out[k]` is the only high output while the count is k.
- R2: A rising edge on `step_up` advances the count by one while `step_dn` is low.
- R3: A falling edge on `step_dn` advances the count by one while `step_up` is high.
- R4: The count does not change on a falling edge of `step_up`, on a rising edge of `step_dn`, on a rising `step_up` while `step_dn` is high, or on a falling `step_dn` while `step_up` is low.
- R5: While `master_clr` or `rst` is high, the counter goes to count zero: `dec_out` = 10'b0000000001 and `carry_n` = 1. This overrides both count inputs and the debug load.
- R6: `carry_n` is 0 exactly while the count is 5, 6, 7, 8 or 9, and 1 for counts 0 to 4. It therefore rises on the wrap from 9 to 0.
- R7: In every legal state exactly one bit of `dec_out` is high.
- R8: From any of the 32 ring patterns, after at most 11 advances the counter is in the legal loop. From then on, each advance moves the single high output up by one position, modulo 10.
- R9: With `dbg_load` high for one clock (and `master_clr` low), the ring takes `dbg_value`, with bit i going to stage i. The legal pattern for count k, for k from 1 to 5, has its k low bits set. For example, 5'b00111 gives count 3.
- R10: Either input can serve as an enable for the other, at the cost of one extra count. Raising `step_up` while `step_dn` is already low counts once. Lowering `step_dn` while `step_up` is already high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, to count zero |
| master_clr | input | 1 | Synchronous master clear, to count zero, highest priority |
| step_up | input | 1 | Count input, rising-edge sense, gated by `step_dn` low |
| step_dn | input | 1 | Count input, falling-edge sense, gated by `step_up` high |
| dbg_load | input | 1 | Debug strobe that writes `dbg_value` into the ring |
| dbg_value | input | 5 | Ring pattern to load, bit i to stage i |
| dec_out | output | 10 | Registered one-hot decoded count |
| carry_n | output | 1 | Registered active-low upper-half carry |

## Verification
The count is driven in three ways: by pulses on `step_up` with `step_dn` low, by pulses on `step_dn` with `step_up` high, and by a mixed enable sequence. Together these separate the two advancing edge senses from the four non-advancing edge and level cases, and they show the extra count that comes from using one input as an enable. A full decade with a wrap checks the one-hot sequence together with the carry boundary between counts 4 and 5, and again on the wrap from 9 to 0. Each of the 32 ring patterns is loaded and then advanced eleven times. This shows whether the correction logic really closes every illegal loop, rather than only the ones a few samples happen to reach.

// File: rtl/ring10_pkg.sv
package ring10_pkg;

  // Control decoded for the ring register each cycle, in priority order
  typedef struct packed {
    logic clr;   // master clear or reset
    logic load;  // debug write
    logic adv;   // one legal advance
  } ring_ctrl_t;

  // Worst-case advances allowed to get back into the legal loop
  localparam int RECOVER_LIMIT = 11;

endpackage

// File: rtl/ring10_edge_detect.sv
module ring10_edge_detect #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_up,
  input  logic step_dn,
  output logic adv
);
  localparam int MSB = SYNC_DEPTH - 1;

  logic [MSB:0] up_sync;
  logic [MSB:0] dn_sync;
  logic         up_prev;
  logic         dn_prev;
  logic         up_now;
  logic         dn_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_sync <= '0;
      dn_sync <= '0;
      up_prev <= 1'b0;
      dn_prev <= 1'b0;
    end else begin
      up_sync <= {up_sync[MSB-1:0], step_up};
      dn_sync <= {dn_sync[MSB-1:0], step_dn};
      up_prev <= up_sync[MSB];
      dn_prev <= dn_sync[MSB];
    end
  end

  assign up_now = up_sync[MSB];
  assign dn_now = dn_sync[MSB];

  // The gating level comes from the same synchronized sample as the edge
  always_comb begin
    adv = (up_now & ~up_prev & ~dn_now) |
          (~dn_now & dn_prev & up_now);
  end
endmodule

// File: rtl/ring10_core.sv
module ring10_core
  import ring10_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ring_ctrl_t        ctrl,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] state_q
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] nxt;
  logic              upper_any;

  // Stage 1 takes stage 0 unless that would spread a stray one: a 1,0
  // pair at the bottom is legal only when all higher stages are clear.
  always_comb begin
    upper_any = |state_q[TOP:2];
    nxt       = {state_q[TOP-1:0], ~state_q[TOP]};
    nxt[1]    = state_q[0] & (state_q[1] | ~upper_any);
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clr) begin
      state_q <= '0;
    end else if (ctrl.load) begin
      state_q <= load_val;
    end else if (ctrl.adv) begin
      state_q <= nxt;
    end
  end
endmodule

// File: rtl/ring10_decode.sv
module ring10_decode #(
  parameter int STAGES = 5,
  localparam int NOUT = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [STAGES-1:0] state,
  output logic [NOUT-1:0]   dec_q,
  output logic              carry_n_q
);
  localparam int TOP = STAGES - 1;

  logic [NOUT-1:0] dec_d;

  // Each output looks at one adjacent pair of the twisted ring
  for (genvar k = 0; k < NOUT; k++) begin : g_pair
    if (k == 0) begin : g_zero
      assign dec_d[k] = ~state[TOP] & ~state[0];
    end else if (k < STAGES) begin : g_fill
      assign dec_d[k] = state[k-1] & ~state[k];
    end else if (k == STAGES) begin : g_full
      assign dec_d[k] = state[TOP] & state[0];
    end else begin : g_drain
      assign dec_d[k] = ~state[k-STAGES-1] & state[k-STAGES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dec_q     <= NOUT'(1);
      carry_n_q <= 1'b1;
    end else begin
      dec_q     <= dec_d;
      carry_n_q <= ~state[TOP];
    end
  end
endmodule

// File: rtl/ring10_counter.sv
module ring10_counter
  import ring10_pkg::*;
#(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  master_clr,
  input  logic                  step_up,
  input  logic                  step_dn,
  input  logic                  dbg_load,
  input  logic [STAGES-1:0]     dbg_value,
  output logic [2*STAGES-1:0]   dec_out,
  output logic                  carry_n
);
  logic              adv_pulse;
  logic [STAGES-1:0] state_q;
  ring_ctrl_t        ctrl;

  ring10_edge_detect #(.SYNC_DEPTH(SYNC_DEPTH)) edge_i (
    .clk     (clk),
    .rst     (rst),
    .step_up (step_up),
    .step_dn (step_dn),
    .adv     (adv_pulse)
  );

  always_comb begin
    ctrl.clr  = master_clr;
    ctrl.load = dbg_load;
    ctrl.adv  = adv_pulse;
  end

  ring10_core #(.STAGES(STAGES)) core_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .load_val (dbg_value),
    .state_q  (state_q)
  );

  ring10_decode #(.STAGES(STAGES)) dec_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (master_clr),
    .state     (state_q),
    .dec_q     (dec_out),
    .carry_n_q (carry_n)
  );
endmodule

// File: rtl/ring10_checker.sv
module ring10_checker
  import ring10_pkg::*;
#(
  parameter int STAGES = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                master_clr,
  input logic                dbg_load,
  input logic                adv,
  input logic [STAGES-1:0]   state_q,
  input logic [2*STAGES-1:0] dec_out,
  input logic                carry_n
);
  localparam int NOUT = 2 * STAGES;

  function automatic logic is_legal(input logic [STAGES-1:0] s);
    logic hit;
    logic [31:0] full;
    logic [31:0] code;
    hit  = 1'b0;
    full = (32'd1 << STAGES) - 32'd1;
    for (int k = 0; k < NOUT; k++) begin
      if (k <= STAGES) code = (32'd1 << k) - 32'd1;
      else             code = full & ~((32'd1 << (k - STAGES)) - 32'd1);
      if (s == code[STAGES-1:0]) hit = 1'b1;
    end
    return hit;
  endfunction

  logic       legal_now;
  logic [4:0] rec_cnt;

  assign legal_now = is_legal(state_q);

  always_ff @(posedge clk) begin
    if (rst || master_clr || dbg_load || legal_now) begin
      rec_cnt <= '0;
    end else if (adv && rec_cnt != 5'd31) begin
      rec_cnt <= rec_cnt + 5'd1;
    end
  end

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!adv && !master_clr && !dbg_load) |=> $stable(state_q)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    master_clr |=> (dec_out == NOUT'(1) && carry_n)); // R5

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    ($countones(dec_out) == 1) |-> (carry_n == !(|dec_out[NOUT-1:STAGES]))); // R6

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    legal_now |=> ($countones(dec_out) == 1)); // R7

  AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (rst)
    rec_cnt <= 5'(RECOVER_LIMIT)); // R8
endmodule

bind ring10_counter ring10_checker #(.STAGES(STAGES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .master_clr (master_clr),
  .dbg_load   (dbg_load),
  .adv        (adv_pulse),
  .state_q    (state_q),
  .dec_out    (dec_out),
  .carry_n    (carry_n)
);

// File: tb/ring10_counter_tb_top.sv
`timescale 1ns/1ps
module ring10_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_clr = 1'b0;
  logic       step_up = 1'b0;
  logic       step_dn = 1'b0;
  logic       dbg_load = 1'b0;
  logic [4:0] dbg_value = '0;
  logic [9:0] dec_out;
  logic       carry_n;

  always #2.5 clk = ~clk;

  ring10_counter dut_i (
    .clk(clk), .rst(rst), .master_clr(master_clr),
    .step_up(step_up), .step_dn(step_dn),
    .dbg_load(dbg_load), .dbg_value(dbg_value),
    .dec_out(dec_out), .carry_n(carry_n)
  );

  typedef struct {
    logic [9:0] exp_dec;
    logic       exp_carry;
    string      tag;
  } exp_item_t;

  exp_item_t q[$];
  event      chk_ev;
  int        n_tests = 0;
  int        n_fail = 0;
  bit        done = 1'b0;

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_item_t it;
        it = q.pop_front();
        n_tests++;
        if (dec_out !== it.exp_dec || carry_n !== it.exp_carry) begin
          n_fail++;
          $display("FAIL %s: dec_out=%b carry_n=%b expected dec_out=%b carry_n=%b",
                   it.tag, dec_out, carry_n, it.exp_dec, it.exp_carry);
        end
      end
    end
  end

  task automatic expect_count(input int k, input string tag);
    exp_item_t it;
    it.exp_dec   = 10'(1) << k;
    it.exp_carry = (k < 5);
    it.tag       = tag;
    q.push_back(it);
    ->chk_ev;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_up(input logic v);
    step_up = v;
    settle();
  endtask

  task automatic set_dn(input logic v);
    step_dn = v;
    settle();
  endtask

  task automatic pulse_clear();
    master_clr = 1'b1;
    @(negedge clk);
    master_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_code(input logic [4:0] v);
    dbg_value = v;
    dbg_load  = 1'b1;
    @(negedge clk);
    dbg_load  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int hot_index(input logic [9:0] d);
    for (int i = 0; i < 10; i++) if (d[i]) return i;
    return -1;
  endfunction

  // Driver
  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    expect_count(0, "R5 reset state");

    // R1 / R2 / R6: full decade on step_up rising edges, wrap to zero
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      set_up(1'b1);
      cnt = (cnt + 1) % 10;
      expect_count(cnt, "R2 rise of step_up counts");
      set_up(1'b0);
      expect_count(cnt, "R1 R6 sequence and carry");
    end

    // R3: step_up held high, falling step_dn counts, rising does not (R4)
    set_up(1'b1);
    cnt = (cnt + 1) % 10;
    expect_count(cnt, "R2 rise before step_dn use");
    for (int i = 0; i < 6; i++) begin
      set_dn(1'b1);
      expect_count(cnt, "R4 rising step_dn ignored");
      set_dn(1'b0);
      cnt = (cnt + 1) % 10;
      expect_count(cnt, "R3 falling step_dn counts");
    end

    // R4: step_dn high blocks rising step_up
    set_dn(1'b1);
    set_up(1'b0);
    expect_count(cnt, "R4 falling step_up ignored");
    set_up(1'b1);
    expect_count(cnt, "R4 rise of step_up blocked by step_dn high");
    set_up(1'b0);
    // R4: falling step_dn with step_up low
    set_dn(1'b0);
    expect_count(cnt, "R4 falling step_dn blocked by step_up low");

    // R10: enable tricks give one extra count each
    pulse_clear();
    expect_count(0, "R5 master clear");
    set_up(1'b1);
    expect_count(1, "R10 raising step_up with step_dn low");
    set_dn(1'b1);
    set_up(1'b0);
    expect_count(1, "R4 no count while disabling");
    set_up(1'b1);
    expect_count(1, "R4 step_up rise while step_dn high");
    set_dn(1'b0);
    expect_count(2, "R10 lowering step_dn with step_up high");

    // R5: master clear overrides load and count edges
    master_clr = 1'b1;
    dbg_value  = 5'b00111;
    dbg_load   = 1'b1;
    @(negedge clk);
    dbg_load   = 1'b0;
    set_up(1'b0);
    set_up(1'b1);
    set_up(1'b0);
    expect_count(0, "R5 clear overrides load and steps");
    master_clr = 1'b0;
    settle();
    expect_count(0, "R5 still zero after clear released");

    // R9: debug load of legal codes
    load_code(5'b00111);
    expect_count(3, "R9 load 00111 is count 3");
    load_code(5'b11100);
    expect_count(7, "R9 load 11100 is count 7");
    set_up(1'b1);
    set_up(1'b0);
    expect_count(8, "R9 advance after load");

    // R8: every ring code recovers within 11 advances
    for (int code = 0; code < 32; code++) begin
      int idx;
      pulse_clear();
      load_code(5'(code));
      for (int a = 0; a < 11; a++) begin
        set_up(1'b1);
        set_up(1'b0);
      end
      n_tests++;
      if ($countones(dec_out) != 1) begin
        n_fail++;
        $display("FAIL R8 code %0d: dec_out=%b expected one-hot", code, dec_out);
      end
      idx = hot_index(dec_out);
      if (idx >= 0) begin
        set_up(1'b1);
        set_up(1'b0);
        expect_count((idx + 1) % 10, "R8 R7 legal step after recovery");
      end
    end

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule